// File: doc/BRIEF.md
# Embedded-Operation Status Word Generator

This block forms the word a host reads from a flash array while an internal program or erase algorithm is running, and after such an algorithm has failed. The operation engine reports what it is doing through a few level inputs: busy, error, supply fault, erase begun, multi-word busy and the bit being programmed. The block turns these into a status word with a polling bit, two toggle bits, sticky error and supply-fault flags, an erase-begun flag and a multi-word handshake bit.

The two toggle bits are flip-flops that change only when a read strobe arrives. The main toggle changes on every read, at any address. The alternate toggle changes only when the block addressed by the read is relevant: during an erase this is the block being erased, and after an erase has failed it is any block flagged in the failed-block mask. The caller supplies the block-index bits of each read address. With 2^17-word blocks these are address bits 21:17.

Top module: `flash_status_gen`

## Requirements
- R1: While no operation is active (busy low and no error held), status_o and active_o are 0 and read strobes change no internal toggle state.
- R2: Bit 7 is the inverse of prog_bit_i during a word or multi-word program (op kinds 0 and 1) and 0 during an erase (op kinds 2 block, 3 chip).
- R3: While active, bit 6 inverts after every clock edge with rd_strobe_i high, whatever the block index, and holds otherwise.
- R4: An err_i pulse while busy sets bit 5. Bit 5 stays set after busy falls, active_o stays high, and bit 6 keeps toggling on reads.
- R5: A vfail_i pulse while busy sets bit 4 for the rest of the operation.
- R6: Bit 3 becomes 1 on the edge after erase_begun_i is seen high while busy during an erase. It stays 0 during program operations.
- R7: During a block erase, bit 2 inverts only on reads whose block index equals the target block. During a chip erase it inverts on every read. During a program it stays 0.
- R8: After an erase has failed, bit 2 inverts only on reads whose block index has its bit set in fail_mask_i.
- R9: Bit 0 is mw_busy_i during a multi-word program and 0 otherwise. Bit 1 and bits 15:8 are always 0.
- R10: op_start_i clears both toggles and the error, supply-fault and erase-begun flags, and latches the op kind and target block.
- R11: clr_cmd_i with busy low clears bits 5 and 4. With busy high it is ignored.
- R12: The block index of a read is rd_blk_i. The target test compares it with the latched target block, and the fail test selects bit rd_blk_i of fail_mask_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | New operation begins this cycle |
| op_kind_i | input | 2 | 0 word, 1 multi-word, 2 block erase, 3 chip erase |
| tgt_blk_i | input | BLK_W | Block targeted by the new operation |
| busy_i | input | 1 | Operation engine running |
| err_i | input | 1 | Engine reports failure to reach intended data |
| vfail_i | input | 1 | Programming supply out of range |
| erase_begun_i | input | 1 | Erase pulses have actually started |
| prog_bit_i | input | 1 | Bit 7 of the word being programmed |
| mw_busy_i | input | 1 | Multi-word engine programming (1) or waiting (0) |
| clr_cmd_i | input | 1 | Reset command accepted by the command decoder |
| rd_strobe_i | input | 1 | One host read of the status word this cycle |
| rd_blk_i | input | BLK_W | Block-index bits of the read address |
| fail_mask_i | input | NUM_BLK | One bit per block that failed to erase |
| status_o | output | 16 | Status word |
| active_o | output | 1 | Status word is being returned instead of array data |

## Verification
The bound checker watches, on every cycle, the toggle and hold rule for bit 6, the idle-zero rule, the persistence of the error bit and its clearing by a reset command, the clearing done by an operation start, the reserved bits, and the rule that bit 7 is 0 whenever the erase-begun flag is set. The qualification of bit 2 by block and by failed-block mask, the value of bit 7 against prog_bit_i, and the multi-word handshake depend on which operation and target are latched. Only the bench's sweeps over every op kind, target block and read block show these.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        OPK_WORD  = 2'd0,
        OPK_MULTI = 2'd1,
        OPK_BLOCK = 2'd2,
        OPK_CHIP  = 2'd3
    } opk_e;

    localparam int STAT_W   = 16;
    localparam int BIT_MWR  = 0;
    localparam int BIT_ALT  = 2;
    localparam int BIT_ERS  = 3;
    localparam int BIT_VF   = 4;
    localparam int BIT_ERR  = 5;
    localparam int BIT_TGL  = 6;
    localparam int BIT_POLL = 7;

    function automatic logic opk_is_erase(opk_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/fsg_blk_decode.sv
module fsg_blk_decode #(
    parameter int BLK_W = 5,
    localparam int NUM_BLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0]   rd_blk_i,
    input  logic [BLK_W-1:0]   tgt_blk_i,
    input  logic [NUM_BLK-1:0] fail_mask_i,
    output logic               in_tgt_o,
    output logic               in_fail_o
);

    logic [NUM_BLK-1:0] hit;

    // one-hot decode of the block addressed by the read
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_hit
        assign hit[b] = (rd_blk_i == BLK_W'(b));
    end

    assign in_tgt_o  = hit[tgt_blk_i];
    assign in_fail_o = |(hit & fail_mask_i);

endmodule

// File: rtl/fsg_core.sv
module fsg_core
    import fsg_pkg::*;
#(
    parameter int BLK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start_i,
    input  logic [1:0]       op_kind_i,
    input  logic [BLK_W-1:0] tgt_blk_i,
    input  logic             busy_i,
    input  logic             err_i,
    input  logic             vfail_i,
    input  logic             erase_begun_i,
    input  logic             clr_cmd_i,
    input  logic             rd_strobe_i,
    input  logic             in_tgt_i,
    input  logic             in_fail_i,
    output opk_e             op_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             active_o,
    output logic             tgl_main_o,
    output logic             tgl_alt_o,
    output logic             err_o,
    output logic             vf_o,
    output logic             ers_o
);

    typedef struct packed {
        opk_e             op;
        logic [BLK_W-1:0] blk;
        logic             tgl_main;
        logic             tgl_alt;
        logic             err;
        logic             vf;
        logic             ers;
    } st_t;

    st_t  st_d, st_q;
    logic active;
    logic alt_qual;

    assign active = busy_i | st_q.err;

    // which reads advance the alternate toggle
    always_comb begin
        alt_qual = 1'b0;
        if (opk_is_erase(st_q.op)) begin
            if (st_q.err)
                alt_qual = in_fail_i;
            else
                alt_qual = (st_q.op == OPK_CHIP) || in_tgt_i;
        end
    end

    always_comb begin
        st_d = st_q;
        if (op_start_i) begin
            st_d.op       = opk_e'(op_kind_i);
            st_d.blk      = tgt_blk_i;
            st_d.tgl_main = 1'b0;
            st_d.tgl_alt  = 1'b0;
            st_d.err      = 1'b0;
            st_d.vf       = 1'b0;
            st_d.ers      = 1'b0;
        end else begin
            if (clr_cmd_i && !busy_i) begin
                st_d.err = 1'b0;
                st_d.vf  = 1'b0;
            end
            if (busy_i && err_i)
                st_d.err = 1'b1;
            if (busy_i && vfail_i)
                st_d.vf = 1'b1;
            if (busy_i && erase_begun_i && opk_is_erase(st_q.op))
                st_d.ers = 1'b1;
            if (rd_strobe_i && active) begin
                st_d.tgl_main = ~st_q.tgl_main;
                if (alt_qual)
                    st_d.tgl_alt = ~st_q.tgl_alt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op       <= OPK_WORD;
            st_q.blk      <= '0;
            st_q.tgl_main <= 1'b0;
            st_q.tgl_alt  <= 1'b0;
            st_q.err      <= 1'b0;
            st_q.vf       <= 1'b0;
            st_q.ers      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_o       = st_q.op;
    assign blk_o      = st_q.blk;
    assign active_o   = active;
    assign tgl_main_o = st_q.tgl_main;
    assign tgl_alt_o  = st_q.tgl_alt;
    assign err_o      = st_q.err;
    assign vf_o       = st_q.vf;
    assign ers_o      = st_q.ers;

endmodule

// File: rtl/fsg_pack.sv
module fsg_pack
    import fsg_pkg::*;
(
    input  opk_e              op_i,
    input  logic              active_i,
    input  logic              tgl_main_i,
    input  logic              tgl_alt_i,
    input  logic              err_i,
    input  logic              vf_i,
    input  logic              ers_i,
    input  logic              prog_bit_i,
    input  logic              mw_busy_i,
    output logic [STAT_W-1:0] word_o
);

    always_comb begin
        word_o = '0;
        if (active_i) begin
            word_o[BIT_POLL] = opk_is_erase(op_i) ? 1'b0 : ~prog_bit_i;
            word_o[BIT_TGL]  = tgl_main_i;
            word_o[BIT_ERR]  = err_i;
            word_o[BIT_VF]   = vf_i;
            word_o[BIT_ERS]  = ers_i;
            word_o[BIT_ALT]  = tgl_alt_i;
            word_o[BIT_MWR]  = (op_i == OPK_MULTI) && mw_busy_i;
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int BLK_W = 5,
    localparam int NUM_BLK = 1 << BLK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start_i,
    input  logic [1:0]         op_kind_i,
    input  logic [BLK_W-1:0]   tgt_blk_i,
    input  logic               busy_i,
    input  logic               err_i,
    input  logic               vfail_i,
    input  logic               erase_begun_i,
    input  logic               prog_bit_i,
    input  logic               mw_busy_i,
    input  logic               clr_cmd_i,
    input  logic               rd_strobe_i,
    input  logic [BLK_W-1:0]   rd_blk_i,
    input  logic [NUM_BLK-1:0] fail_mask_i,
    output logic [15:0]        status_o,
    output logic               active_o
);

    opk_e             op_q;
    logic [BLK_W-1:0] blk_q;
    logic             active;
    logic             tgl_main, tgl_alt, err_q, vf_q, ers_q;
    logic             in_tgt, in_fail;
    logic [STAT_W-1:0] word;

    fsg_blk_decode #(.BLK_W(BLK_W)) u_dec (
        .rd_blk_i    (rd_blk_i),
        .tgt_blk_i   (blk_q),
        .fail_mask_i (fail_mask_i),
        .in_tgt_o    (in_tgt),
        .in_fail_o   (in_fail)
    );

    fsg_core #(.BLK_W(BLK_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_start_i    (op_start_i),
        .op_kind_i     (op_kind_i),
        .tgt_blk_i     (tgt_blk_i),
        .busy_i        (busy_i),
        .err_i         (err_i),
        .vfail_i       (vfail_i),
        .erase_begun_i (erase_begun_i),
        .clr_cmd_i     (clr_cmd_i),
        .rd_strobe_i   (rd_strobe_i),
        .in_tgt_i      (in_tgt),
        .in_fail_i     (in_fail),
        .op_o          (op_q),
        .blk_o         (blk_q),
        .active_o      (active),
        .tgl_main_o    (tgl_main),
        .tgl_alt_o     (tgl_alt),
        .err_o         (err_q),
        .vf_o          (vf_q),
        .ers_o         (ers_q)
    );

    fsg_pack u_pack (
        .op_i       (op_q),
        .active_i   (active),
        .tgl_main_i (tgl_main),
        .tgl_alt_i  (tgl_alt),
        .err_i      (err_q),
        .vf_i       (vf_q),
        .ers_i      (ers_q),
        .prog_bit_i (prog_bit_i),
        .mw_busy_i  (mw_busy_i),
        .word_o     (word)
    );

    assign status_o = word;
    assign active_o = active;

endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_start_i,
    input logic        busy_i,
    input logic        clr_cmd_i,
    input logic        rd_strobe_i,
    input logic [15:0] status_o,
    input logic        active_o
);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> status_o == 16'h0000);

    p_tgl_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && rd_strobe_i && !op_start_i) |=>
            (!active_o || status_o[6] != $past(status_o[6])));

    p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !rd_strobe_i && !op_start_i) |=>
            (!active_o || $stable(status_o[6])));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !clr_cmd_i && !op_start_i) |=> (status_o[5] && active_o));

    p_ers_erase_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> !status_o[7]);

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15:8] == 8'h00) && !status_o[1]);

    p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_i |=> (status_o[6:2] == 5'b00000));

    p_clr_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd_i && !busy_i && !op_start_i) |=> (!status_o[5] && !status_o[4]));

endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_start_i  (op_start_i),
    .busy_i      (busy_i),
    .clr_cmd_i   (clr_cmd_i),
    .rd_strobe_i (rd_strobe_i),
    .status_o    (status_o),
    .active_o    (active_o)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;

    localparam int BW = 3;
    localparam int NB = 1 << BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 0, busy = 0, err = 0, vfail = 0, ebeg = 0;
    logic          pbit = 0, mwb = 0, clr = 0, strobe = 0;
    logic [1:0]    kind = 0;
    logic [BW-1:0] tgt = 0, rblk = 0;
    logic [NB-1:0] fmask = 0;
    logic [15:0]   status;
    logic          active;

    int n_chk = 0;
    int n_err = 0;

    // expectation model, built from the requirements
    logic [1:0]    m_op;
    logic [BW-1:0] m_blk;
    logic          m_main, m_alt, m_err, m_vf, m_ers;

    always #10 clk = ~clk;

    flash_status_gen #(.BLK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .op_start_i(op_start), .op_kind_i(kind),
        .tgt_blk_i(tgt), .busy_i(busy), .err_i(err), .vfail_i(vfail),
        .erase_begun_i(ebeg), .prog_bit_i(pbit), .mw_busy_i(mwb),
        .clr_cmd_i(clr), .rd_strobe_i(strobe), .rd_blk_i(rblk),
        .fail_mask_i(fmask), .status_o(status), .active_o(active)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w = 16'h0;
        if (busy || m_err) begin
            w[7] = m_op[1] ? 1'b0 : ~pbit;
            w[6] = m_main;
            w[5] = m_err;
            w[4] = m_vf;
            w[3] = m_ers;
            w[2] = m_alt;
            w[0] = (m_op == 2'd1) && mwb;
        end
        return w;
    endfunction

    function automatic logic alt_moves();
        if (!m_op[1]) return 1'b0;
        if (m_err) return fmask[rblk];
        return (m_op == 2'd3) || (rblk == m_blk);
    endfunction

    task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic look(input string tag);
        #1;
        chk(tag, {active, status}, {(busy | m_err), exp_word()});
    endtask

    task automatic tick();
        logic act = busy | m_err;
        if (op_start) begin
            m_op = kind; m_blk = tgt;
            m_main = 0; m_alt = 0; m_err = 0; m_vf = 0; m_ers = 0;
        end else begin
            if (strobe && act) begin
                if (alt_moves()) m_alt = ~m_alt;
                m_main = ~m_main;
            end
            if (clr && !busy) begin m_err = 0; m_vf = 0; end
            if (busy && err) m_err = 1;
            if (busy && vfail) m_vf = 1;
            if (busy && ebeg && m_op[1]) m_ers = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [BW-1:0] b, input string tag);
        rblk = b;
        strobe = 1;
        look(tag);
        tick();
        strobe = 0;
    endtask

    task automatic start(input logic [1:0] k, input logic [BW-1:0] t);
        op_start = 1; kind = k; tgt = t; busy = 1;
        tick();
        op_start = 0;
        look("R10 start clears state");
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        m_op = 0; m_blk = 0; m_main = 0; m_alt = 0; m_err = 0; m_vf = 0; m_ers = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        look("R1 reset state");

        // R1: idle reads return zero and advance nothing
        rd(3'd5, "R1 idle read");
        rd(3'd2, "R1 idle read");
        start(2'd0, 3'd0);
        busy = 0;
        tick();
        look("R1 idle after op");

        // sweep of every kind, target and read block: R2 R3 R6 R7 R9 R12
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < NB; t++) begin
                start(2'(k), BW'(t));
                for (int pass = 0; pass < 2; pass++) begin
                    for (int a = 0; a < NB; a++) begin
                        pbit = a[0] ^ t[0];
                        mwb  = a[1];
                        if (a == 3) ebeg = 1;
                        rd(BW'(a), "R2 R3 R6 R7 R9 R12 sweep");
                    end
                end
                // R3: no strobe, no change
                tick();
                look("R3 hold without strobe");
                ebeg = 0; busy = 0;
                tick();
                look("R1 operation over");
            end
        end

        // R5: supply fault during a program
        start(2'd1, 3'd4);
        vfail = 1;
        tick();
        vfail = 0;
        rd(3'd1, "R5 supply fault flag");
        rd(3'd6, "R5 supply fault flag held");
        busy = 0;
        tick();
        look("R5 op over");
        start(2'd1, 3'd4);
        rd(3'd0, "R10 supply fault cleared");

        // R4 R8 R11: block erase fails
        start(2'd2, 3'd2);
        ebeg = 1;
        rd(3'd2, "R7 erase in target");
        rd(3'd3, "R7 erase outside target");
        err = 1;
        tick();
        err = 0;
        clr = 1;
        tick();
        clr = 0;
        look("R11 clear ignored while busy");
        busy = 0; ebeg = 0;
        fmask = 8'b0010_0100;
        tick();
        look("R4 error held after busy");
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < NB; a++)
                rd(BW'(a), "R4 R8 failed-block toggle");
        fmask = 8'b1000_0001;
        for (int a = 0; a < NB; a++)
            rd(BW'(a), "R8 other failed mask");
        clr = 1;
        tick();
        clr = 0;
        look("R11 clear after failure");
        rd(3'd0, "R11 idle after clear");

        // chip erase failure uses the mask, not the chip-wide rule
        start(2'd3, 3'd0);
        err = 1;
        tick();
        err = 0; busy = 0;
        fmask = 8'b0001_0000;
        for (int a = 0; a < NB; a++)
            rd(BW'(a), "R8 chip erase failed");
        clr = 1;
        tick();
        clr = 0;
        look("R11 final clear");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule